// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twelve interrupt sources into one vectored request for a processor core. There is a reset request, a power-down event and ten maskable sources. Six of the maskable sources are active-low external pins. Four are single-cycle pulses from internal units: a timer, two serial channels and a byte DMA engine. Each source is detected according to its own sensitivity rule and held as pending. The pending sources are then gated by an individual mask and a global enable. A fixed priority picks one winner, whose index appears on the vector output while the request line is high.

The core acknowledges a request with a one-cycle strobe. The acknowledge clears the latched event of the winning source and of no other source. Software programs the controller through a small write port with four registers: mask, control, force and clear. Force and clear set or remove latched events directly, which is how software interrupts are raised. Two of the external pins are usable only when the control register enables them. Saving core context and nesting interrupts are the core's job, not this block's.

Top module: `pri_intc`

## Requirements
- R1: After `rstN` is released, `irqReq` is 0, every mask bit is 0 and every control bit is 0. With these defaults a timer pulse raises no request.
- R2: Vector values equal source indices. Index 0 is the `resetReq` level and wins over everything. Index 1 is power-down and comes next. Among indices 2 to 11 the lowest pending index wins.
- R3: A source with index 2 to 11 can request only when its own bit in the mask register (write select 0, bit position equal to the index) is 1. Control bit 0, the global enable, must also be 1.
- R4: Level-sensitive pins are `extReqN[1]` (index 3) and `extReqN[2]` (index 4). They are pending only while low, and a change is visible two clock edges after it reaches the pin.
- R5: `extReqN[3]` (index 5) is always falling-edge sensitive. Its event is latched three edges after the fall, and it stays pending after the pin returns high until it is acknowledged or cleared.
- R6: Control bits 1, 2 and 3 select edge mode (1) or level mode (0) for `extReqN[0]` (index 2), `extReqN[4]` (index 6) and `extReqN[5]` (index 7).
- R7: While control bit 4 is 0, `extReqN[4]` and `extReqN[5]` raise no request.
- R8: A one-cycle high on `intPulse[k]` latches source index 8+k on the next edge. Bit 0 is the timer, bits 1 and 2 are the serial channels and bit 3 is the DMA engine.
- R9: An acknowledge (`irqAck` high while `irqReq` is high) clears only the winner's latched event. Other pending sources stay pending.
- R10: A write with select 2 sets the latched events at the 1 bits of `regData` for indices 2 to 11. A write with select 3 clears them.
- R11: A `pwrDownPulse` raises vector 1 regardless of the mask and the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extReqN | input | 6 | Active-low external request pins |
| intPulse | input | 4 | Internal unit request pulses (timer, serial 0, serial 1, DMA) |
| pwrDownPulse | input | 1 | Power-down event pulse |
| resetReq | input | 1 | Reset request level |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 mask, 1 control, 2 force, 3 clear |
| regData | input | 12 | Register write data |
| irqAck | input | 1 | Core acknowledge of the current request |
| irqReq | output | 1 | Request to the core |
| irqVector | output | 4 | Index of the winning source |

## Verification
On every cycle, the assertions check that a reset request always owns the vector and that a pending power-down always beats the maskable sources. They also check that the reported vector is the lowest eligible index and that any maskable winner is unmasked and globally enabled. Synchronizer latency, the latching of edges and the survival of those latches past the pin's release can only be shown by the bench's timed scenarios. The same holds for the acknowledge clearing a single latch and for software force and clear.

// File: rtl/pri_intc_pkg.sv
package pri_intc_pkg;
  localparam int NUM_SRC  = 12;
  localparam int VEC_W    = $clog2(NUM_SRC);
  localparam int N_EXT    = 6;
  localparam int N_INT    = 4;
  localparam int N_NMI    = 2;   // reset request and power-down: never masked
  localparam int CTRL_W   = 5;

  localparam int IDX_RESET = 0;
  localparam int IDX_PDOWN = 1;
  localparam int IDX_INT0  = 8;

  // control register layout
  localparam int CB_GEN    = 0;
  localparam int CB_EDGE0  = 1;
  localparam int CB_PAIREN = 4;

  localparam logic [NUM_SRC-1:0] MASKABLE = {{(NUM_SRC-N_NMI){1'b1}}, {N_NMI{1'b0}}};

  typedef struct packed {
    logic              globalEn;
    logic              pairEn;
    logic [2:0]        edgeSel;   // [0] idx2, [1] idx6, [2] idx7
  } ctrlCfg_t;

  typedef struct packed {
    logic               ackFire;
    logic [NUM_SRC-1:0] ackOneHot;
  } ctlStrobe_t;
endpackage

// File: rtl/pri_intc_sync.sv
module pri_intc_sync #(
  parameter int WIDTH = 6,
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) stage[k] <= {WIDTH{RESET_VAL}};
    end else begin
      stage[0] <= dIn;
      for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/pri_intc_datapath.sv
module pri_intc_datapath
  import pri_intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_EXT-1:0]   extReqN,
  input  logic [N_INT-1:0]   intPulse,
  input  logic               pwrDownPulse,
  input  logic               resetReq,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [NUM_SRC-1:0] regData,
  input  ctlStrobe_t         strobe,
  output logic [NUM_SRC-1:0] eligible,
  output logic [NUM_SRC-1:0] maskReg,
  output ctrlCfg_t           cfg
);
  logic [N_EXT-1:0]   extSync;
  logic [N_EXT-1:0]   extPrev;
  logic [N_EXT-1:0]   extFall;
  logic [NUM_SRC-1:0] latchQ;
  logic [NUM_SRC-1:0] levelAct;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] pending;
  logic               swForce;
  logic               swClear;

  pri_intc_sync #(.WIDTH(N_EXT), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rstN(rstN), .dIn(extReqN), .dOut(extSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= '1;
    else       extPrev <= extSync;
  end

  assign extFall = extPrev & ~extSync;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      cfg     <= '0;
    end else if (regWe) begin
      if (regSel == 2'd0) maskReg <= regData & MASKABLE;
      if (regSel == 2'd1) begin
        cfg.globalEn <= regData[CB_GEN];
        cfg.edgeSel  <= regData[CB_EDGE0 +: 3];
        cfg.pairEn   <= regData[CB_PAIREN];
      end
    end
  end

  assign swForce = regWe && (regSel == 2'd2);
  assign swClear = regWe && (regSel == 2'd3);

  // level-sensitive contributions
  always_comb begin
    levelAct            = '0;
    levelAct[IDX_RESET] = resetReq;
    levelAct[2]         = ~extSync[0] & ~cfg.edgeSel[0];
    levelAct[3]         = ~extSync[1];
    levelAct[4]         = ~extSync[2];
    levelAct[6]         = ~extSync[4] & ~cfg.edgeSel[1] & cfg.pairEn;
    levelAct[7]         = ~extSync[5] & ~cfg.edgeSel[2] & cfg.pairEn;
  end

  // edge / pulse events that set a latch
  always_comb begin
    setVec            = '0;
    setVec[IDX_PDOWN] = pwrDownPulse;
    setVec[2]         = extFall[0] & cfg.edgeSel[0];
    setVec[5]         = extFall[3];
    setVec[6]         = extFall[4] & cfg.edgeSel[1] & cfg.pairEn;
    setVec[7]         = extFall[5] & cfg.edgeSel[2] & cfg.pairEn;
    for (int k = 0; k < N_INT; k++) setVec[IDX_INT0 + k] = intPulse[k];
    if (swForce) setVec = setVec | (regData & MASKABLE);
  end

  always_comb begin
    clrVec = strobe.ackFire ? strobe.ackOneHot : '0;
    if (swClear) clrVec = clrVec | (regData & MASKABLE);
  end

  // new events win over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) latchQ <= '0;
    else       latchQ <= ((latchQ & ~clrVec) | setVec) & ~NUM_SRC'(1 << IDX_RESET);
  end

  assign pending = latchQ | levelAct;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    if (g < N_NMI) begin : g_nmi
      assign eligible[g] = pending[g];
    end else begin : g_mask
      assign eligible[g] = pending[g] & maskReg[g] & cfg.globalEn;
    end
  end
endmodule

// File: rtl/pri_intc_control.sv
module pri_intc_control
  import pri_intc_pkg::*;
(
  input  logic [NUM_SRC-1:0] eligible,
  input  logic               irqAck,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVector,
  output ctlStrobe_t         strobe
);
  logic [VEC_W-1:0] winner;

  // scan from the top so the lowest index is written last and wins
  always_comb begin
    winner = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) winner = VEC_W'(i);
    end
  end

  assign irqReq    = |eligible;
  assign irqVector = winner;

  always_comb begin
    strobe.ackFire   = irqAck & irqReq;
    strobe.ackOneHot = strobe.ackFire ? (NUM_SRC'(1) << winner) : '0;
  end
endmodule

// File: rtl/pri_intc.sv
module pri_intc
  import pri_intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [5:0]   extReqN,
  input  logic [3:0]   intPulse,
  input  logic         pwrDownPulse,
  input  logic         resetReq,
  input  logic         regWe,
  input  logic [1:0]   regSel,
  input  logic [11:0]  regData,
  input  logic         irqAck,
  output logic         irqReq,
  output logic [3:0]   irqVector
);
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] maskReg;
  ctrlCfg_t           cfg;
  ctlStrobe_t         strobe;

  pri_intc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extReqN(extReqN), .intPulse(intPulse),
    .pwrDownPulse(pwrDownPulse), .resetReq(resetReq), .regWe(regWe),
    .regSel(regSel), .regData(regData), .strobe(strobe),
    .eligible(eligible), .maskReg(maskReg), .cfg(cfg)
  );

  pri_intc_control u_ctl (
    .eligible(eligible), .irqAck(irqAck), .irqReq(irqReq),
    .irqVector(irqVector), .strobe(strobe)
  );
endmodule

// File: rtl/pri_intc_checker.sv
module pri_intc_checker
  import pri_intc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               resetReq,
  input logic               irqReq,
  input logic [VEC_W-1:0]   irqVector,
  input logic [NUM_SRC-1:0] eligible,
  input logic [NUM_SRC-1:0] maskReg,
  input logic               globalEn
);
  // R2: reset request always owns the vector
  a_r2_reset_wins: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (irqReq && irqVector == '0));

  // R2: vector is in range and is the lowest eligible source
  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (int'(irqVector) < NUM_SRC && eligible[irqVector]
                && ((eligible & ((NUM_SRC'(1) << irqVector) - NUM_SRC'(1))) == '0)));

  // R3: a maskable winner is unmasked and globally enabled
  a_r3_gated: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && int'(irqVector) >= N_NMI) |-> (maskReg[irqVector] && globalEn));

  // R11: a pending power-down beats every maskable source
  a_r11_pdown_first: assert property (@(posedge clk) disable iff (!rstN)
    (eligible[IDX_PDOWN] && !resetReq) |-> (irqReq && irqVector == VEC_W'(IDX_PDOWN)));

  // R1: a request implies some eligible source
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (eligible != '0));
endmodule

bind pri_intc pri_intc_checker u_chk (
  .clk(clk), .rstN(rstN), .resetReq(resetReq), .irqReq(irqReq),
  .irqVector(irqVector), .eligible(eligible), .maskReg(maskReg),
  .globalEn(cfg.globalEn)
);

// File: tb/pri_intc_bench.sv
module pri_intc_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  extReqN = 6'h3F;
  logic [3:0]  intPulse = '0;
  logic        pwrDownPulse = 1'b0;
  logic        resetReq = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [11:0] regData = '0;
  logic        irqAck = 1'b0;
  logic        irqReq;
  logic [3:0]  irqVector;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pri_intc u_pri_intc (
    .clk(clk), .rstN(rstN), .extReqN(extReqN), .intPulse(intPulse),
    .pwrDownPulse(pwrDownPulse), .resetReq(resetReq), .regWe(regWe),
    .regSel(regSel), .regData(regData), .irqAck(irqAck),
    .irqReq(irqReq), .irqVector(irqVector)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // encodes request state: -1 means no request, otherwise the vector
  function automatic int observed();
    return irqReq ? int'(irqVector) : -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [11:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regData = data;
    @(negedge clk);
    regWe = 1'b0;
    #1;
  endtask

  task automatic ack();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    #1;
  endtask

  task automatic pulseInt(input int k);
    @(negedge clk);
    intPulse[k] = 1'b1;
    @(negedge clk);
    intPulse[k] = 1'b0;
    #1;
  endtask

  task automatic testReset();
    chk("R1 idle after reset", observed(), -1);
    pulseInt(0);
    tick(1);
    chk("R1 default mask blocks timer", observed(), -1);
    regWrite(2'd3, 12'hFFF);
  endtask

  task automatic testResetReq();
    regWrite(2'd0, 12'hFFC);
    regWrite(2'd1, 12'h001);
    pulseInt(3);
    chk("R8 dma latched", observed(), 11);
    @(negedge clk); resetReq = 1'b1; #1;
    chk("R2 reset request wins", observed(), 0);
    @(negedge clk); resetReq = 1'b0; #1;
    chk("R2 dma after reset request", observed(), 11);
    ack();
    chk("R9 dma cleared", observed(), -1);
  endtask

  task automatic testLevel();
    @(negedge clk); extReqN[1] = 1'b0; #1;
    tick(1);
    chk("R4 one edge not yet visible", observed(), -1);
    tick(1);
    chk("R4 level visible after two edges", observed(), 3);
    ack();
    chk("R9 ack leaves level pending", observed(), 3);
    regWrite(2'd0, 12'hFF4);
    chk("R3 masked level", observed(), -1);
    regWrite(2'd0, 12'hFFC);
    @(negedge clk); extReqN[1] = 1'b1; #1;
    tick(2);
    chk("R4 level gone after release", observed(), -1);
  endtask

  task automatic testEdge();
    @(negedge clk); extReqN[3] = 1'b0;
    @(negedge clk); extReqN[3] = 1'b1; #1;
    tick(1);
    chk("R5 not latched after two edges", observed(), -1);
    tick(1);
    chk("R5 latched on third edge", observed(), 5);
    tick(3);
    chk("R5 held after pin high", observed(), 5);
    ack();
    chk("R5 cleared by ack", observed(), -1);
  endtask

  task automatic testPriority();
    @(negedge clk); intPulse = 4'b1001;
    @(negedge clk); intPulse = 4'b0000; #1;
    chk("R2 timer beats dma", observed(), 8);
    ack();
    chk("R9 only timer cleared", observed(), 11);
    ack();
    chk("R9 dma cleared", observed(), -1);
  endtask

  task automatic testPowerDown();
    regWrite(2'd1, 12'h000);
    regWrite(2'd0, 12'h000);
    @(negedge clk); pwrDownPulse = 1'b1;
    @(negedge clk); pwrDownPulse = 1'b0; #1;
    chk("R11 pdown ignores mask and enable", observed(), 1);
    @(negedge clk); resetReq = 1'b1; #1;
    chk("R2 reset above pdown", observed(), 0);
    @(negedge clk); resetReq = 1'b0; #1;
    ack();
    chk("R11 pdown cleared", observed(), -1);
  endtask

  task automatic testGlobalEnable();
    regWrite(2'd0, 12'hFFC);
    pulseInt(3);
    chk("R3 global enable off blocks", observed(), -1);
    regWrite(2'd1, 12'h001);
    chk("R3 latched dma after enable", observed(), 11);
    ack();
  endtask

  task automatic testProgrammable();
    @(negedge clk); extReqN[0] = 1'b0; #1;
    tick(2);
    chk("R6 idx2 level mode", observed(), 2);
    @(negedge clk); extReqN[0] = 1'b1; #1;
    tick(2);
    chk("R6 idx2 level released", observed(), -1);
    regWrite(2'd1, 12'h003);
    @(negedge clk); extReqN[0] = 1'b0;
    @(negedge clk); extReqN[0] = 1'b1; #1;
    tick(4);
    chk("R6 idx2 edge mode latched", observed(), 2);
    ack();
    chk("R6 idx2 edge cleared", observed(), -1);
    regWrite(2'd1, 12'h001);
  endtask

  task automatic testPair();
    @(negedge clk); extReqN[4] = 1'b0; #1;
    tick(3);
    chk("R7 pair pin ignored while disabled", observed(), -1);
    regWrite(2'd1, 12'h011);
    chk("R7 pair pin active when enabled", observed(), 6);
    @(negedge clk); extReqN[4] = 1'b1; #1;
    tick(2);
    chk("R7 pair released", observed(), -1);
  endtask

  task automatic testSoftware();
    regWrite(2'd2, 12'h600);
    chk("R10 force sets idx9", observed(), 9);
    regWrite(2'd3, 12'h200);
    chk("R10 clear idx9 leaves idx10", observed(), 10);
    regWrite(2'd3, 12'h400);
    chk("R10 clear idx10", observed(), -1);
    regWrite(2'd2, 12'h003);
    chk("R10 force ignores idx0 idx1", observed(), -1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(3);
    @(negedge clk); rstN = 1'b1; #1;
    tick(1);
    testReset();
    testResetReq();
    testLevel();
    testEdge();
    testPriority();
    testPowerDown();
    testGlobalEnable();
    testProgrammable();
    testPair();
    testSoftware();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule